// File: doc/BRIEF.md
# Codec Command Slot Interface

This block gives software a small register window for reaching the control registers of an audio codec over a frame-based link. Software loads the data slot first and then the command slot. Writing the command slot starts one access on a request/response port toward the codec register model. The request carries a read flag, a 7-bit register index and a 16-bit data value. When a read completes, the returned value is stored in the receive slot registers, and a flag register shows whether each slot is empty, busy or holding valid data. The bit-level serial framing and the codec's register contents are handled elsewhere.

Register window, selected by `bus_addr`. Every register is 20 bits wide.
- 0: command slot (read/write). Bit 19 is the read flag: 1 means read and 0 means write. Bits 18:12 hold the codec register index.
- 1: data slot (read/write). Bits 19:4 hold the 16-bit write value.
- 2: receive command slot (read-only).
- 3: receive data slot (read-only).
- 4: flags (read-only). Bit 0 is command-slot empty. Bit 1 is data-slot empty. Bit 2 is both-slots empty. Bits 3 and 4 are the command and data receive-busy flags. Bits 5 and 6 are the command and data receive-valid flags.
- 5 to 7: read as zero.

The sequencer has three states:
- IDLE: waits for a command-slot write. That write is the *launch* transition, which moves to ISSUE.
- ISSUE: drives `cmd_valid` for exactly one cycle, then always moves to AWAIT.
- AWAIT: waits for `rsp_valid`. The *complete* transition then returns to IDLE, capturing the read data if the access was a read.

Top module: `codec_slot_if`

## Requirements
- R1: After reset, the flags register reads 0x07 (both transmit-empty flags and the combined flag set). Every other register reads zero, and `cmd_valid` is low.
- R2: A data-slot write (address 1) stores the word and clears flag bits 1 and 2. It starts no request.
- R3: A command-slot write (address 0) in IDLE stores the word and clears flag bits 0 and 2. In the next cycle only, `cmd_valid` is high, with `cmd_read` = command bit 19, `cmd_index` = command bits 18:12 and `cmd_wdata` = data-slot bits 19:4.
- R4: Launching a read (command bit 19 = 1) sets both receive-busy flags (bits 3, 4) and clears both receive-valid flags (bits 5, 6).
- R5: When `rsp_valid` arrives in AWAIT for a read, the registers update on that clock edge. The receive command slot gets the launched command word with bit 19 cleared. The receive data slot gets `rsp_data` shifted left by 4. The busy flags clear and the valid flags set.
- R6: When `rsp_valid` arrives in AWAIT for a write, the block returns to IDLE. The receive registers and the receive flags stay unchanged, whatever `rsp_data` holds.
- R7: A command-slot write made while a request is outstanding is ignored. No request is issued, and the command slot keeps its earlier value.
- R8: Reading the receive command slot (address 2) clears both receive-valid flags from the next cycle on.
- R9: `rsp_valid` arriving when no request is waiting for a response has no effect on any register or flag.
- R10: Writes to addresses 2 to 7 change nothing, and addresses 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (needed for the read-clear side effect) |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 20 | Register write data |
| bus_rdata | output | 20 | Register read data, combinational from `bus_addr` |
| cmd_valid | output | 1 | One-cycle codec access request |
| cmd_read | output | 1 | Request is a read |
| cmd_index | output | 7 | Codec register index |
| cmd_wdata | output | 16 | Codec write value |
| rsp_valid | input | 1 | Codec response strobe |
| rsp_data | input | 16 | Codec read value |

## Verification
The bench checks the following corner cases:
- Response latency of one cycle, which is the earliest a response can be accepted. A design that acted on a response during the issue cycle would capture data too early. A design that mistimed AWAIT would miss the response and hang.
- A command-slot write poked in while a request is outstanding. A design that accepted it would send a second request or overwrite the command slot.
- Write responses that carry junk data. A design that captured them would corrupt the receive registers.
- Stray responses in IDLE. A design that accepted them would corrupt the receive registers.
- Reading the receive command slot. A design that got the read-clear wrong would leave the valid flags stuck.
- Index 0x7F and bit 19 set together with nonzero low bits. These expose a misplaced shift or field boundary.

// File: rtl/codec_slot_pkg.sv
package codec_slot_pkg;
    localparam int SLOT_W   = 20;
    localparam int ADDR_W   = 3;
    localparam int IDX_W    = 7;
    localparam int CDATA_W  = 16;
    localparam int RNW_BIT  = 19;
    localparam int IDX_LSB  = 12;
    localparam int DATA_LSB = 4;
    localparam int FLAG_W   = 7;

    localparam logic [ADDR_W-1:0] A_CMD_TX  = 3'd0;
    localparam logic [ADDR_W-1:0] A_DAT_TX  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMD_RX  = 3'd2;
    localparam logic [ADDR_W-1:0] A_DAT_RX  = 3'd3;
    localparam logic [ADDR_W-1:0] A_FLAGS   = 3'd4;

    localparam int F_CMD_EMPTY = 0;
    localparam int F_DAT_EMPTY = 1;
    localparam int F_ALL_EMPTY = 2;
    localparam int F_CMD_BUSY  = 3;
    localparam int F_DAT_BUSY  = 4;
    localparam int F_CMD_VALID = 5;
    localparam int F_DAT_VALID = 6;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_AWAIT = 2'd2
    } seq_state_t;
endpackage

// File: rtl/codec_slot_seq.sv
module codec_slot_seq
    import codec_slot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic rnw_in,
    input  logic rsp_valid,
    output logic launch,
    output logic issue,
    output logic busy,
    output logic rd_done
);
    seq_state_t state, state_nx;
    logic       pend_rd;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cmd_wr)    state_nx = ST_ISSUE;
            ST_ISSUE:                state_nx = ST_AWAIT;
            ST_AWAIT: if (rsp_valid) state_nx = ST_IDLE;
            default:                 state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            pend_rd <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && cmd_wr) pend_rd <= rnw_in;
        end
    end

    always_comb begin
        launch  = (state == ST_IDLE) && cmd_wr;
        issue   = (state == ST_ISSUE);
        busy    = (state != ST_IDLE);
        rd_done = (state == ST_AWAIT) && rsp_valid && pend_rd;
    end
endmodule

// File: rtl/codec_slot_regfile.sv
module codec_slot_regfile
    import codec_slot_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [SLOT_W-1:0]  bus_wdata,
    input  logic               launch,
    input  logic               rd_done,
    input  logic [CDATA_W-1:0] rsp_data,
    output logic [SLOT_W-1:0]  cmd_tx,
    output logic [SLOT_W-1:0]  dat_tx,
    output logic [SLOT_W-1:0]  cmd_rx,
    output logic [SLOT_W-1:0]  dat_rx,
    output logic [FLAG_W-1:0]  flags
);
    localparam logic [SLOT_W-1:0] RNW_MASK = SLOT_W'(1) << RNW_BIT;

    logic cmd_empty, dat_empty, rx_busy, rx_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_tx    <= '0;
            dat_tx    <= '0;
            cmd_rx    <= '0;
            dat_rx    <= '0;
            cmd_empty <= 1'b1;
            dat_empty <= 1'b1;
            rx_busy   <= 1'b0;
            rx_valid  <= 1'b0;
        end else begin
            if (launch) begin
                cmd_tx    <= bus_wdata;
                cmd_empty <= 1'b0;
                if (bus_wdata[RNW_BIT]) begin
                    rx_busy  <= 1'b1;
                    rx_valid <= 1'b0;
                end
            end
            if (bus_wr && bus_addr == A_DAT_TX) begin
                dat_tx    <= bus_wdata;
                dat_empty <= 1'b0;
            end
            if (bus_rd && bus_addr == A_CMD_RX) rx_valid <= 1'b0;
            if (rd_done) begin
                cmd_rx   <= cmd_tx & ~RNW_MASK;
                dat_rx   <= {rsp_data, {DATA_LSB{1'b0}}};
                rx_busy  <= 1'b0;
                rx_valid <= 1'b1;
            end
        end
    end

    always_comb begin
        flags              = '0;
        flags[F_CMD_EMPTY] = cmd_empty;
        flags[F_DAT_EMPTY] = dat_empty;
        flags[F_ALL_EMPTY] = cmd_empty && dat_empty;
        flags[F_CMD_BUSY]  = rx_busy;
        flags[F_DAT_BUSY]  = rx_busy;
        flags[F_CMD_VALID] = rx_valid;
        flags[F_DAT_VALID] = rx_valid;
    end
endmodule

// File: rtl/codec_slot_rdmux.sv
module codec_slot_rdmux
    import codec_slot_pkg::*;
(
    input  logic [ADDR_W-1:0] sel,
    input  logic [SLOT_W-1:0] cmd_tx,
    input  logic [SLOT_W-1:0] dat_tx,
    input  logic [SLOT_W-1:0] cmd_rx,
    input  logic [SLOT_W-1:0] dat_rx,
    input  logic [FLAG_W-1:0] flags,
    output logic [SLOT_W-1:0] rdata
);
    always_comb begin
        case (sel)
            A_CMD_TX: rdata = cmd_tx;
            A_DAT_TX: rdata = dat_tx;
            A_CMD_RX: rdata = cmd_rx;
            A_DAT_RX: rdata = dat_rx;
            A_FLAGS:  rdata = SLOT_W'(flags);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/codec_slot_if.sv
module codec_slot_if
    import codec_slot_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [SLOT_W-1:0]  bus_wdata,
    output logic [SLOT_W-1:0]  bus_rdata,
    output logic               cmd_valid,
    output logic               cmd_read,
    output logic [IDX_W-1:0]   cmd_index,
    output logic [CDATA_W-1:0] cmd_wdata,
    input  logic               rsp_valid,
    input  logic [CDATA_W-1:0] rsp_data
);
    logic              cmd_wr, launch, issue, busy_w, rd_done;
    logic [SLOT_W-1:0] cmd_tx, dat_tx, cmd_rx, dat_rx;
    logic [FLAG_W-1:0] flag_w;

    assign cmd_wr = bus_wr && (bus_addr == A_CMD_TX);

    codec_slot_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .rnw_in    (bus_wdata[RNW_BIT]),
        .rsp_valid (rsp_valid),
        .launch    (launch),
        .issue     (issue),
        .busy      (busy_w),
        .rd_done   (rd_done)
    );

    codec_slot_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .launch    (launch),
        .rd_done   (rd_done),
        .rsp_data  (rsp_data),
        .cmd_tx    (cmd_tx),
        .dat_tx    (dat_tx),
        .cmd_rx    (cmd_rx),
        .dat_rx    (dat_rx),
        .flags     (flag_w)
    );

    codec_slot_rdmux u_mux (
        .sel    (bus_addr),
        .cmd_tx (cmd_tx),
        .dat_tx (dat_tx),
        .cmd_rx (cmd_rx),
        .dat_rx (dat_rx),
        .flags  (flag_w),
        .rdata  (bus_rdata)
    );

    always_comb begin
        cmd_valid = issue;
        cmd_read  = cmd_tx[RNW_BIT];
        cmd_index = cmd_tx[IDX_LSB +: IDX_W];
        cmd_wdata = dat_tx[DATA_LSB +: CDATA_W];
    end
endmodule

// File: rtl/codec_slot_if_chk.sv
module codec_slot_if_chk
    import codec_slot_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              cmd_valid,
    input logic              cmd_read,
    input logic [IDX_W-1:0]  cmd_index,
    input logic              rsp_valid,
    input logic              busy_w,
    input logic [FLAG_W-1:0] flag_w
);
    p_one_shot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    p_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CMD_TX && !busy_w) |=> cmd_valid);

    p_hold_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CMD_TX && busy_w)
        |=> (!cmd_valid && $stable(cmd_index) && $stable(cmd_read)));

    p_busy_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_w[F_CMD_BUSY] && flag_w[F_CMD_VALID]));

    p_valid_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_w[F_CMD_VALID]) |-> $past(flag_w[F_CMD_BUSY]));

    p_stray_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_w && rsp_valid && !bus_wr && !bus_rd) |=> $stable(flag_w));
endmodule

bind codec_slot_if codec_slot_if_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .cmd_valid (cmd_valid),
    .cmd_read  (cmd_read),
    .cmd_index (cmd_index),
    .rsp_valid (rsp_valid),
    .busy_w    (busy_w),
    .flag_w    (flag_w)
);

// File: tb/codec_slot_if_test.sv
module codec_slot_if_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr, bus_rd;
    logic [2:0]  bus_addr;
    logic [19:0] bus_wdata, bus_rdata;
    logic        cmd_valid, cmd_read;
    logic [6:0]  cmd_index;
    logic [15:0] cmd_wdata;
    logic        rsp_valid;
    logic [15:0] rsp_data;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [15:0] model [128];
    logic [19:0] e_cmd_tx, e_dat_tx, e_cmd_rx, e_dat_rx;
    bit e_cmd_e, e_dat_e, e_busy, e_val;

    always #5 clk = ~clk;

    codec_slot_if uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmd_valid(cmd_valid), .cmd_read(cmd_read), .cmd_index(cmd_index),
        .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    function automatic logic [19:0] exp_flags();
        return {13'd0, e_val, e_val, e_busy, e_busy, e_cmd_e & e_dat_e, e_dat_e, e_cmd_e};
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(logic [2:0] a, logic [19:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [2:0] a, output logic [19:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
        if (a == 3'd2) e_val = 0;
    endtask

    task automatic check_all(string req);
        logic [19:0] v;
        bus_read(3'd4, v); check(req, "flags", v, exp_flags());
        bus_read(3'd0, v); check(req, "cmd slot", v, e_cmd_tx);
        bus_read(3'd1, v); check(req, "data slot", v, e_dat_tx);
        bus_read(3'd3, v); check(req, "rx data slot", v, e_dat_rx);
        bus_read(3'd2, v); check(req, "rx cmd slot", v, e_cmd_rx);
        bus_read(3'd4, v); check("R8", "flags after rx read", v, exp_flags());
    endtask

    task automatic transaction(logic [19:0] w1, logic [19:0] w2, int lat, bit poke);
        logic [19:0] v;
        bus_write(3'd1, w2);
        e_dat_tx = w2; e_dat_e = 0;
        check("R2", "no request on data write", cmd_valid, 0);
        bus_read(3'd4, v); check("R2", "flags after data write", v, exp_flags());
        bus_write(3'd0, w1);
        e_cmd_tx = w1; e_cmd_e = 0;
        if (w1[19]) begin e_busy = 1; e_val = 0; end
        check("R3", "cmd_valid", cmd_valid, 1);
        check("R3", "cmd_read", cmd_read, w1[19]);
        check("R3", "cmd_index", cmd_index, w1[18:12]);
        check("R3", "cmd_wdata", cmd_wdata, w2[19:4]);
        @(negedge clk);
        check("R3", "cmd_valid one cycle", cmd_valid, 0);
        if (poke) begin
            bus_write(3'd0, ~w1);
            check("R7", "no request while busy", cmd_valid, 0);
            @(negedge clk);
            check("R7", "no late request", cmd_valid, 0);
        end
        repeat (lat - 1) @(negedge clk);
        rsp_valid = 1'b1;
        rsp_data  = w1[19] ? model[w1[18:12]] : 16'($urandom);
        @(negedge clk);
        rsp_valid = 1'b0;
        if (w1[19]) begin
            e_cmd_rx = w1 & ~20'h80000;
            e_dat_rx = {model[w1[18:12]], 4'h0};
            e_busy = 0; e_val = 1;
            check_all("R5");
        end else begin
            model[w1[18:12]] = w2[19:4];
            check_all(poke ? "R7" : "R6");
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [19:0] v;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 128; i++) model[i] = 16'(i * 16'h0307) ^ 16'hA55A;
        rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
        rsp_valid = 0; rsp_data = 0;
        e_cmd_tx = 0; e_dat_tx = 0; e_cmd_rx = 0; e_dat_rx = 0;
        e_cmd_e = 1; e_dat_e = 1; e_busy = 0; e_val = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1", "cmd_valid", cmd_valid, 0);
        bus_read(3'd4, v); check("R1", "flags", v, 20'h7);
        check_all("R1");

        // R10 read-only and unused addresses
        bus_write(3'd2, 20'hFFFFF);
        bus_write(3'd3, 20'hFFFFF);
        bus_write(3'd4, 20'hFFFFF);
        bus_write(3'd6, 20'hFFFFF);
        bus_read(3'd5, v); check("R10", "unused addr 5", v, 0);
        bus_read(3'd7, v); check("R10", "unused addr 7", v, 0);
        check_all("R10");

        // R9 stray response while idle
        @(negedge clk); rsp_valid = 1; rsp_data = 16'hBEEF;
        @(negedge clk); rsp_valid = 0;
        check_all("R9");

        // directed corners
        transaction({1'b1, 7'h7F, 12'hFFF}, 20'hFFFFF, 1, 1'b0);
        transaction({1'b0, 7'h7F, 12'h123}, 20'h9ABCD, 1, 1'b0);
        transaction({1'b1, 7'h7F, 12'h000}, 20'h00000, 3, 1'b1);
        transaction({1'b0, 7'h00, 12'hABC}, 20'h5555F, 2, 1'b1);
        transaction({1'b1, 7'h00, 12'h001}, 20'h12345, 1, 1'b0);

        // R9 stray response after a completed read
        @(negedge clk); rsp_valid = 1; rsp_data = 16'h1234;
        @(negedge clk); rsp_valid = 0;
        check_all("R9");

        for (int k = 0; k < 40; k++) begin
            logic [19:0] w1, w2;
            w1 = 20'($urandom);
            w2 = 20'($urandom);
            transaction(w1, w2, 1 + int'($urandom % 4), ($urandom % 4) == 0);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule